// File: doc/BRIEF.md
# Serial Display-Data and Key-Readout Port

This block is the host-facing serial port of a vacuum-fluorescent display controller. A host drives a data line, a shift clock and an enable line; the block answers on an active-low, open-drain style data-out line. Every transaction starts with an eight-bit address clocked in while enable is low. Enable then rises, and one of two things follows. With the write address, the host sends an 80-bit frame. With the key address, the block shifts out a 25-bit key image followed by a sleep-acknowledge bit.

A write frame is stored when enable falls, and only if exactly 80 bits arrived. The two bits at the end of the frame form a direction field. It picks one of three segment banks, each holding 56 segment bits. The first bank also carries the port-mode bits, the sleep bits, the dimmer word and the first sleep-current bit. The second bank carries the other two sleep-current bits. The decoded fields go straight to the display timing, dimming, port and key-scan logic.

All pins are oversampled by the system clock. Blanking does not clear the stored registers, so a host can load a complete picture while the display is dark.

Top module: `vfd_ser_if`

## Requirements
- R1: After `rst_n` is released, all three segment banks are zero. So are `port_mode`, `sleep_ctl`, `sleep_mode`, `sleep_cur` and `dimmer`, and `do_low` is 0.
- R2: The address is the last eight bits sampled on rising `sclk` while `ce` is low, taken LSB first. Value 0x8E selects a write and 0x8F selects a key read. If any other value arrives, or fewer than eight bits arrive before `ce` rises, the following transfer changes no register and `do_low` stays 0.
- R3: During a write, frame bit k is the k-th bit sampled on rising `sclk` while `ce` is high. The frame is stored on the falling edge of `ce` only when exactly 80 bits were sampled. A frame of 79 or 81 bits changes nothing.
- R4: Frame bits 78 and 79, in send order, select the bank. (0,0) selects bank 1, (0,1) selects bank 2 and (1,0) selects bank 3. (1,1) discards the frame.
- R5: A bank-1 frame sets `seg_bank1` from bits 0..55 and `sleep_cur[0]` from bit 56. It sets `port_mode[3:0]` from bits 61..64, `sleep_ctl[1:0]` from bits 65..66 and `dimmer[9:0]` from bits 67..76. Lower bit numbers map to lower output bits.
- R6: A bank-2 frame sets `seg_bank2` from bits 0..55, `sleep_cur[1]` from bit 66 and `sleep_cur[2]` from bit 67. A bank-3 frame sets only `seg_bank3`, from bits 0..55. No frame alters the fields of another bank, even when its filler bits are non-zero.
- R7: `sleep_mode` is 1 when either sleep bit is 1, and 0 when both are 0.
- R8: On a key read, `do_low` shows the inverse of `key_image[0]` once `ce` has risen. Each falling `sclk` edge advances to the next key bit. The 26th bit is the sleep acknowledge, equal to `sleep_mode`. After the 26th falling edge, `do_low` is 0.
- R9: With `ce` low and no read in progress, `do_low` follows `key_req`. With `ce` high and no key read selected, `do_low` is 0.
- R10: While `blank_n` is low, `do_low` is 0 at all times, including during a key read. Write frames are still stored while `blank_n` is low.
- R11: `read_done` pulses for one cycle when `ce` falls after a key read in which all 26 bits were shifted out while `blank_n` was high. It does not pulse in any other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_n | input | 1 | Active-low blank; forces data-out released |
| sclk | input | 1 | Serial shift clock from host |
| ce | input | 1 | Transfer enable from host |
| din | input | 1 | Serial data from host |
| key_req | input | 1 | Key scanner asks the host to read keys |
| key_image | input | 25 | Debounced key matrix image, bit 0 sent first |
| do_low | output | 1 | 1 pulls the open-drain data-out line low |
| read_done | output | 1 | One-cycle pulse after a complete key read |
| seg_bank1 | output | 56 | Segment data for digit 1 |
| seg_bank2 | output | 56 | Segment data for digit 2 |
| seg_bank3 | output | 56 | Segment data for digit 3 |
| port_mode | output | 4 | Per-pin segment/general-output select |
| sleep_ctl | output | 2 | Sleep control bits |
| sleep_mode | output | 1 | Sleep mode active |
| sleep_cur | output | 3 | Sleep current select bits |
| dimmer | output | 10 | Dimmer duty word |

## Verification
The hardest condition to reach from the pins is a frame that looks valid in every way but one. Examples are 79 or 81 bits behind a correct address, a seven-bit address followed by a correct frame, a (1,1) direction field, or a bank-3 frame whose filler carries non-zero bits at the bank-1 control positions. The stimulus table builds each of these from separate field values plus a bit count, and a model in the bench decides whether each one may land. Key reads are walked edge by edge with the sleep bit both set and clear. They are repeated while blanked, to show that the line stays released and no completion pulse appears.

// File: rtl/vfd_ser_pkg.sv
package vfd_ser_pkg;

    // Transfer kind chosen by the address byte
    typedef enum logic [1:0] {
        XM_IDLE  = 2'd0,
        XM_WRITE = 2'd1,
        XM_READ  = 2'd2
    } xfer_e;

endpackage

// File: rtl/vfd_ser_sync.sv
// Synchronises the three host pins and produces edge pulses.
module vfd_ser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic ce,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic ce_rise,
    output logic ce_fall,
    output logic ce_lvl,
    output logic din_lvl
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sc;
        logic [STAGES-1:0] en;
        logic [STAGES-1:0] di;
        logic              sc_prev;
        logic              en_prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sc      = {st_q.sc[STAGES-2:0], sclk};
        st_d.en      = {st_q.en[STAGES-2:0], ce};
        st_d.di      = {st_q.di[STAGES-2:0], din};
        st_d.sc_prev = st_q.sc[TOP];
        st_d.en_prev = st_q.en[TOP];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_rise = st_q.sc[TOP] & ~st_q.sc_prev;
    assign sclk_fall = ~st_q.sc[TOP] & st_q.sc_prev;
    assign ce_rise   = st_q.en[TOP] & ~st_q.en_prev;
    assign ce_fall   = ~st_q.en[TOP] & st_q.en_prev;
    assign ce_lvl    = st_q.en[TOP];
    assign din_lvl   = st_q.di[TOP];
endmodule

// File: rtl/vfd_ser_rx.sv
// Address capture, frame shifting, length check and bank steering.
module vfd_ser_rx
    import vfd_ser_pkg::*;
#(
    parameter int               ADDR_W  = 8,
    parameter int               FRAME_W = 80,
    parameter int               BANKS   = 3,
    parameter logic [ADDR_W-1:0] WR_ADDR = 8'h8E,
    parameter logic [ADDR_W-1:0] RD_ADDR = 8'h8F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               ce_rise,
    input  logic               ce_fall,
    input  logic               ce_lvl,
    input  logic               din_lvl,
    output xfer_e              mode,
    output logic [FRAME_W-1:0] frame,
    output logic [BANKS-1:0]   commit_sel,
    output logic               rd_start,
    output logic               rd_stop
);
    localparam int ACW   = $clog2(ADDR_W + 1);
    localparam int FCW   = $clog2(FRAME_W + 2);
    localparam int DIR_A = FRAME_W - 2;   // first direction bit sent
    localparam int DIR_B = FRAME_W - 1;   // second direction bit sent

    typedef struct packed {
        logic [ADDR_W-1:0]  addr_sh;
        logic [ACW-1:0]     addr_cnt;
        xfer_e              mode;
        logic [FRAME_W-1:0] frm;
        logic [FCW-1:0]     fcnt;
    } rx_t;

    rx_t   st_d, st_q;
    xfer_e dec;
    logic  [1:0] dir_idx;

    always_comb begin
        st_d       = st_q;
        commit_sel = '0;
        rd_start   = 1'b0;
        rd_stop    = 1'b0;
        dir_idx    = {st_q.frm[DIR_A], st_q.frm[DIR_B]};

        if (st_q.addr_cnt != ACW'(ADDR_W))  dec = XM_IDLE;
        else if (st_q.addr_sh == WR_ADDR)   dec = XM_WRITE;
        else if (st_q.addr_sh == RD_ADDR)   dec = XM_READ;
        else                                dec = XM_IDLE;

        if (ce_rise) begin
            st_d.mode     = dec;
            st_d.addr_cnt = '0;
            st_d.fcnt     = '0;
            rd_start      = (dec == XM_READ);
        end else if (ce_fall) begin
            rd_stop = (st_q.mode == XM_READ);
            if (st_q.mode == XM_WRITE && st_q.fcnt == FCW'(FRAME_W)) begin
                for (int g = 0; g < BANKS; g++) begin
                    if (int'(dir_idx) == g) commit_sel[g] = 1'b1;
                end
            end
            st_d.mode = XM_IDLE;
        end else if (sclk_rise) begin
            if (!ce_lvl) begin
                st_d.addr_sh = {din_lvl, st_q.addr_sh[ADDR_W-1:1]};
                if (st_q.addr_cnt != ACW'(ADDR_W))
                    st_d.addr_cnt = st_q.addr_cnt + 1'b1;
            end else if (st_q.mode == XM_WRITE) begin
                st_d.frm = {din_lvl, st_q.frm[FRAME_W-1:1]};
                if (st_q.fcnt != FCW'(FRAME_W + 1))
                    st_d.fcnt = st_q.fcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode  = st_q.mode;
    assign frame = st_q.frm;
endmodule

// File: rtl/vfd_ser_banks.sv
// Segment banks and decoded control fields.
module vfd_ser_banks #(
    parameter int FRAME_W = 80,
    parameter int SEG_W   = 56,
    parameter int BANKS   = 3,
    parameter int PORT_W  = 4,
    parameter int SLP_W   = 2,
    parameter int DIM_W   = 10,
    parameter int CUR_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [FRAME_W-1:0]          frame,
    input  logic [BANKS-1:0]            commit_sel,
    output logic [BANKS-1:0][SEG_W-1:0] seg_all,
    output logic [PORT_W-1:0]           port_mode,
    output logic [SLP_W-1:0]            sleep_ctl,
    output logic                        sleep_mode,
    output logic [CUR_W-1:0]            sleep_cur,
    output logic [DIM_W-1:0]            dimmer
);
    // Bank 1 field positions
    localparam int P_C0   = SEG_W;
    localparam int P_PORT = SEG_W + 1 + PORT_W;
    localparam int P_SLP  = P_PORT + PORT_W;
    localparam int P_DIM  = P_SLP + SLP_W;
    // Bank 2 field positions
    localparam int P_C1   = SEG_W + 10;
    localparam int P_C2   = P_C1 + 1;

    typedef struct packed {
        logic [BANKS-1:0][SEG_W-1:0] seg;
        logic [PORT_W-1:0]           port;
        logic [SLP_W-1:0]            slp;
        logic [CUR_W-1:0]            cur;
        logic [DIM_W-1:0]            dim;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < BANKS; g++) begin
            if (commit_sel[g]) st_d.seg[g] = frame[SEG_W-1:0];
        end
        if (commit_sel[0]) begin
            st_d.cur[0] = frame[P_C0];
            st_d.port   = frame[P_PORT +: PORT_W];
            st_d.slp    = frame[P_SLP +: SLP_W];
            st_d.dim    = frame[P_DIM +: DIM_W];
        end
        if (commit_sel[1]) begin
            st_d.cur[1] = frame[P_C1];
            st_d.cur[2] = frame[P_C2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seg_all    = st_q.seg;
    assign port_mode  = st_q.port;
    assign sleep_ctl  = st_q.slp;
    assign sleep_mode = |st_q.slp;
    assign sleep_cur  = st_q.cur;
    assign dimmer     = st_q.dim;
endmodule

// File: rtl/vfd_ser_tx.sv
// Key image readout and data-out line control.
module vfd_ser_tx #(
    parameter int KEY_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank_n,
    input  logic             rd_start,
    input  logic             rd_stop,
    input  logic             sclk_fall,
    input  logic             ce_lvl,
    input  logic             key_req,
    input  logic [KEY_W-1:0] key_image,
    input  logic             sleep_ack,
    output logic             do_low,
    output logic             read_done
);
    localparam int TX_W = KEY_W + 1;
    localparam int TCW  = $clog2(TX_W + 1);

    typedef struct packed {
        logic [TX_W-1:0] sh;
        logic [TCW-1:0]  cnt;
        logic            act;
        logic            pull;
        logic            done;
    } tx_t;

    tx_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (rd_start) begin
            st_d.sh  = {sleep_ack, key_image};
            st_d.cnt = '0;
            st_d.act = 1'b1;
        end else if (rd_stop) begin
            st_d.act  = 1'b0;
            st_d.done = st_q.act && (st_q.cnt == TCW'(TX_W)) && blank_n;
        end else if (st_q.act && sclk_fall && st_q.cnt != TCW'(TX_W)) begin
            st_d.sh  = {1'b0, st_q.sh[TX_W-1:1]};
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (!blank_n)
            st_d.pull = 1'b0;
        else if (st_d.act)
            st_d.pull = (st_d.cnt != TCW'(TX_W)) && !st_d.sh[0];
        else
            st_d.pull = !ce_lvl && key_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign do_low    = st_q.pull;
    assign read_done = st_q.done;
endmodule

// File: rtl/vfd_ser_if.sv
// Top: serial command / key readout port of the display controller.
module vfd_ser_if
    import vfd_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter int FRAME_W     = 80,
    parameter int SEG_W       = 56,
    parameter int KEY_W       = 25,
    parameter int PORT_W      = 4,
    parameter int SLP_W       = 2,
    parameter int DIM_W       = 10,
    parameter int CUR_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_n,
    input  logic              sclk,
    input  logic              ce,
    input  logic              din,
    input  logic              key_req,
    input  logic [KEY_W-1:0]  key_image,
    output logic              do_low,
    output logic              read_done,
    output logic [SEG_W-1:0]  seg_bank1,
    output logic [SEG_W-1:0]  seg_bank2,
    output logic [SEG_W-1:0]  seg_bank3,
    output logic [PORT_W-1:0] port_mode,
    output logic [SLP_W-1:0]  sleep_ctl,
    output logic              sleep_mode,
    output logic [CUR_W-1:0]  sleep_cur,
    output logic [DIM_W-1:0]  dimmer
);
    localparam int BANKS = 3;

    logic sclk_rise, sclk_fall, ce_rise, ce_fall, ce_lvl, din_lvl;
    xfer_e                       mode;
    logic [FRAME_W-1:0]          frame;
    logic [BANKS-1:0]            commit_sel;
    logic                        rd_start, rd_stop;
    logic [BANKS-1:0][SEG_W-1:0] seg_all;

    vfd_ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ce(ce), .din(din),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .ce_rise(ce_rise),
        .ce_fall(ce_fall), .ce_lvl(ce_lvl), .din_lvl(din_lvl)
    );

    vfd_ser_rx #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .BANKS(BANKS)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .ce_rise(ce_rise),
        .ce_fall(ce_fall), .ce_lvl(ce_lvl), .din_lvl(din_lvl), .mode(mode),
        .frame(frame), .commit_sel(commit_sel), .rd_start(rd_start),
        .rd_stop(rd_stop)
    );

    vfd_ser_banks #(
        .FRAME_W(FRAME_W), .SEG_W(SEG_W), .BANKS(BANKS), .PORT_W(PORT_W),
        .SLP_W(SLP_W), .DIM_W(DIM_W), .CUR_W(CUR_W)
    ) u_banks (
        .clk(clk), .rst_n(rst_n), .frame(frame), .commit_sel(commit_sel),
        .seg_all(seg_all), .port_mode(port_mode), .sleep_ctl(sleep_ctl),
        .sleep_mode(sleep_mode), .sleep_cur(sleep_cur), .dimmer(dimmer)
    );

    vfd_ser_tx #(.KEY_W(KEY_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .rd_start(rd_start),
        .rd_stop(rd_stop), .sclk_fall(sclk_fall), .ce_lvl(ce_lvl),
        .key_req(key_req), .key_image(key_image), .sleep_ack(sleep_mode),
        .do_low(do_low), .read_done(read_done)
    );

    assign seg_bank1 = seg_all[0];
    assign seg_bank2 = seg_all[1];
    assign seg_bank3 = seg_all[2];
endmodule

// File: rtl/vfd_ser_if_chk.sv
module vfd_ser_if_chk
    import vfd_ser_pkg::*;
#(
    parameter int SEG_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blank_n,
    input logic             do_low,
    input logic             read_done,
    input xfer_e            mode,
    input logic [2:0]       commit_sel,
    input logic [SEG_W-1:0] seg_bank1,
    input logic [SEG_W-1:0] seg_bank2,
    input logic [SEG_W-1:0] seg_bank3,
    input logic [9:0]       dimmer,
    input logic [3:0]       port_mode,
    input logic [1:0]       sleep_ctl,
    input logic [2:0]       sleep_cur
);
    AST_ONE_BANK_PER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_sel)); // R4

    AST_COMMIT_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_sel != 3'b000) |-> (mode == XM_WRITE)); // R3

    AST_REGS_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_sel == 3'b000) |=> ($stable(seg_bank1) && $stable(seg_bank2) &&
        $stable(seg_bank3) && $stable(dimmer) && $stable(port_mode) &&
        $stable(sleep_ctl) && $stable(sleep_cur))); // R6

    AST_RELEASED_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |=> !do_low); // R10

    AST_RELEASED_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_WRITE) |-> !do_low); // R9

    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |-> $past(mode == XM_READ)); // R11
endmodule

bind vfd_ser_if vfd_ser_if_chk #(.SEG_W(SEG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .do_low(do_low),
    .read_done(read_done), .mode(mode), .commit_sel(commit_sel),
    .seg_bank1(seg_bank1), .seg_bank2(seg_bank2), .seg_bank3(seg_bank3),
    .dimmer(dimmer), .port_mode(port_mode), .sleep_ctl(sleep_ctl),
    .sleep_cur(sleep_cur)
);

// File: tb/vfd_ser_if_test.sv
module vfd_ser_if_test;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;   // clk cycles per serial half period

    logic clk = 1'b0, rst_n = 1'b0, blank_n = 1'b1;
    logic sclk = 1'b0, ce = 1'b0, din = 1'b0, key_req = 1'b0;
    logic [24:0] key_image = '0;
    logic do_low, read_done, sleep_mode;
    logic [55:0] seg_bank1, seg_bank2, seg_bank3;
    logic [3:0] port_mode;
    logic [1:0] sleep_ctl;
    logic [2:0] sleep_cur;
    logic [9:0] dimmer;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfd_ser_if uut (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .sclk(sclk), .ce(ce),
        .din(din), .key_req(key_req), .key_image(key_image), .do_low(do_low),
        .read_done(read_done), .seg_bank1(seg_bank1), .seg_bank2(seg_bank2),
        .seg_bank3(seg_bank3), .port_mode(port_mode), .sleep_ctl(sleep_ctl),
        .sleep_mode(sleep_mode), .sleep_cur(sleep_cur), .dimmer(dimmer)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [6:0]  len;
        logic [1:0]  dir;   // {first sent, second sent}
        logic [55:0] seg;
        logic [1:0]  cb;
        logic [3:0]  port;
        logic [1:0]  slp;
        logic [9:0]  dim;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{8'h8E, 7'd80, 2'b00, 56'hA5A50F0F3C3C99, 2'b01, 4'hA, 2'b00, 10'h3FE}, // R5 bank 1
        '{8'h8E, 7'd80, 2'b01, 56'h123456789ABCDE, 2'b11, 4'h0, 2'b00, 10'h000}, // R6 bank 2
        '{8'h8E, 7'd80, 2'b10, 56'hFEDCBA98765432, 2'b11, 4'h5, 2'b11, 10'h155}, // R6 bank 3, filler ignored
        '{8'h8E, 7'd79, 2'b00, 56'h0000FFFF0000FF, 2'b00, 4'hF, 2'b01, 10'h0AA}, // R3 short
        '{8'h8E, 7'd81, 2'b01, 56'h0F0F0F0F0F0F0F, 2'b00, 4'hF, 2'b01, 10'h0AA}, // R3 long
        '{8'h8E, 7'd80, 2'b11, 56'h33333333333333, 2'b01, 4'h3, 2'b10, 10'h111}, // R4 discard
        '{8'h8D, 7'd80, 2'b00, 56'h77777777777777, 2'b01, 4'h7, 2'b10, 10'h222}, // R2 wrong address
        '{8'h8E, 7'd80, 2'b00, 56'h80000000000001, 2'b00, 4'hF, 2'b10, 10'h001}, // R7 S1 only
        '{8'h8E, 7'd80, 2'b00, 56'h00000000000002, 2'b01, 4'h1, 2'b01, 10'h200}, // R7 S0 only
        '{8'h8E, 7'd80, 2'b00, 56'h00000000000004, 2'b00, 4'h2, 2'b00, 10'h0FF}  // R7 back to normal
    };

    int n_chk = 0, n_bad = 0, n_done = 0;
    logic [55:0] m1 = '0, m2 = '0, m3 = '0;
    logic [3:0]  mport = '0;
    logic [1:0]  mslp = '0;
    logic [2:0]  mcur = '0;
    logic [9:0]  mdim = '0;

    always @(posedge clk) if (read_done) n_done <= n_done + 1;

    function automatic logic [79:0] mk_frame(input vec_t v);
        logic [79:0] f = '0;
        f[55:0] = v.seg;
        if (v.dir == 2'b01) begin
            f[66] = v.cb[0];
            f[67] = v.cb[1];
        end else begin
            f[56]    = v.cb[0];
            f[64:61] = v.port;
            f[66:65] = v.slp;
            f[76:67] = v.dim;
        end
        f[78] = v.dir[1];
        f[79] = v.dir[0];
        return f;
    endfunction

    task automatic model_apply(input vec_t v);
        if (v.addr == 8'h8E && v.len == 7'd80) begin
            case (v.dir)
                2'b00: begin m1 = v.seg; mcur[0] = v.cb[0]; mport = v.port;
                             mslp = v.slp; mdim = v.dim; end
                2'b01: begin m2 = v.seg; mcur[1] = v.cb[0]; mcur[2] = v.cb[1]; end
                2'b10: m3 = v.seg;
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string what, input logic [187:0] act, input logic [187:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic chk_regs(input string what);
        chk(what, {seg_bank1, seg_bank2, seg_bank3, port_mode, sleep_ctl, sleep_mode, sleep_cur, dimmer},
                  {m1, m2, m3, mport, mslp, |mslp, mcur, mdim});
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic serial_bit(input logic b);
        din = b;
        wait_clk(H);
        sclk = 1'b1;
        wait_clk(H);
        sclk = 1'b0;
    endtask

    task automatic send_addr(input logic [7:0] a, input int nbits);
        ce = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) serial_bit(a[i]);
        wait_clk(H);
    endtask

    task automatic write_xfer(input logic [7:0] a, input int abits, input logic [79:0] f, input int len);
        send_addr(a, abits);
        ce = 1'b1;
        wait_clk(H);
        for (int i = 0; i < len; i++) serial_bit(i < 80 ? f[i] : 1'b1);
        wait_clk(H);
        ce = 1'b0;
        wait_clk(2 * H);
    endtask

    task automatic read_keys(input logic sa, input int exp_done, input string tag);
        logic [25:0] img = {sa, key_image};
        int d0 = n_done;
        send_addr(8'h8F, 8);
        ce = 1'b1;
        wait_clk(H);
        chk({tag, " first key bit"}, 188'(do_low), 188'(blank_n & ~img[0]));
        for (int i = 1; i < 26; i++) begin
            sclk = 1'b1; wait_clk(H);
            sclk = 1'b0; wait_clk(H);
            chk($sformatf("%s key bit %0d", tag, i), 188'(do_low), 188'(blank_n & ~img[i]));
        end
        sclk = 1'b1; wait_clk(H);
        sclk = 1'b0; wait_clk(H);
        chk({tag, " released after 26 bits"}, 188'(do_low), 188'(0));
        ce = 1'b0;
        wait_clk(2 * H);
        chk({tag, " completion pulses"}, 188'(n_done - d0), 188'(exp_done));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        vec_t v;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        chk_regs("R1 reset state");
        chk("R1 do_low after reset", 188'(do_low), 188'(0));

        // Table walk: writes, length and address corner cases
        for (int k = 0; k < NV; k++) begin
            v = TBL[k];
            write_xfer(v.addr, 8, mk_frame(v), int'(v.len));
            model_apply(v);
            chk_regs($sformatf("table row %0d (R2..R7)", k));
        end

        // R2: seven address bits then a valid frame
        v = '{8'h8E, 7'd80, 2'b00, 56'h11111111111111, 2'b01, 4'h9, 2'b11, 10'h3AA};
        write_xfer(8'h8E, 7, mk_frame(v), 80);
        chk_regs("R2 seven-bit address ignored");

        // R9: key request visible with ce low, released during a write
        key_req = 1'b1;
        wait_clk(H);
        chk("R9 key_req shown while idle", 188'(do_low), 188'(1));
        send_addr(8'h8E, 8);
        ce = 1'b1;
        wait_clk(H);
        chk("R9 released during write", 188'(do_low), 188'(0));
        ce = 1'b0;
        wait_clk(2 * H);
        key_req = 1'b0;
        wait_clk(H);
        chk("R9 follows key_req low", 188'(do_low), 188'(0));
        chk_regs("R3 empty write ignored");

        // R8/R11: key reads with sleep set, then clear
        key_image = 25'h1A53C96;
        v = '{8'h8E, 7'd80, 2'b00, 56'h00000000000010, 2'b00, 4'h0, 2'b01, 10'h010};
        write_xfer(8'h8E, 8, mk_frame(v), 80);
        model_apply(v);
        chk_regs("R7 sleep via S0");
        read_keys(1'b1, 1, "R8 R11 sleep");
        key_image = 25'h0C3A5F1;
        v.slp = 2'b00;
        write_xfer(8'h8E, 8, mk_frame(v), 80);
        model_apply(v);
        read_keys(1'b0, 1, "R8 R11 normal");

        // R10: blank holds the line released, frames still load
        blank_n = 1'b0;
        v = '{8'h8E, 7'd80, 2'b10, 56'hCAFEF00DBEEF12, 2'b00, 4'h0, 2'b00, 10'h000};
        write_xfer(8'h8E, 8, mk_frame(v), 80);
        model_apply(v);
        chk_regs("R10 frame stored while blank");
        read_keys(1'b0, 0, "R10 R11 blanked read");
        key_req = 1'b1;
        wait_clk(H);
        chk("R10 key_req masked by blank", 188'(do_low), 188'(0));
        key_req = 1'b0;
        blank_n = 1'b1;
        wait_clk(H);

        finish_run();
    end
endmodule